// File: doc/BRIEF.md
# Exception Status and Cause Register Unit

This block holds the three system-control registers that a simple RISC core uses for exceptions. The status word keeps a per-line interrupt mask and a small stack of privilege and interrupt-enable bits. The cause word keeps the pending interrupt flags and the code of the last exception. The third register holds the program counter of the faulting instruction. The unit samples six hardware interrupt lines and two software-set flags. It combines them with the masks and the current enable to form one interrupt request for the core.

When the core reports an exception, the unit pushes the mode/enable stack, switches to kernel mode with interrupts off, and stores the exception code and the faulting address in the same clock. It also presents the single fixed handler address. A return-from-exception pops the stack. The core reads and writes the registers through a small select/data port. Reads are always allowed. Writes are accepted only in kernel mode. A write attempted from user mode is dropped and turned into an exception with the coprocessor-unusable code.

Top module: `exc_ctrl_regs`

## Requirements
- R1: After a synchronous reset, the status, cause and EPC registers read as zero, the unit is in kernel mode, and `irq_req_o` and `priv_fault_o` are low.
- R2: Status (select 0) places mask bit i at bit 8+i. The stack sits in bits 5:0: old KU/IE at 5/4, previous at 3/2, current at 1/0. A kernel write stores only bits 15:8 and 5:0; every other bit reads zero.
- R3: Cause (select 1) holds pending flag i at bit 8+i and the exception code at bits 6:2; all other bits read zero. Flags 7..2 show the level of `irq_hw_i[i-2]` one clock after it is sampled. Flags 1..0 are set and cleared only by kernel writes to cause bits 9:8. The exception code is not writable.
- R4: `irq_req_o` is high exactly when the current IE bit is 1 and at least one line i has both pending flag i and mask bit i set.
- R5: On exception entry, previous KU/IE moves to old, current moves to previous, and current becomes KU=0 (kernel), IE=0. The old pair is lost.
- R6: On exception entry, EPC takes `exc_pc_i` and the code field takes the reported code, both at the same clock edge.
- R7: Return-from-exception copies old to previous and previous to current, and leaves old unchanged.
- R8: When current KU is 1 (user), a register write is ignored and `priv_fault_o` is high in that cycle. At the next edge the unit takes an exception with code 11, and EPC takes `exc_pc_i`.
- R9: Events in one cycle are ranked: reported exception first, then a denied user write, then return-from-exception, then a kernel write. Lower-ranked events in that cycle have no effect. A user write that coincides with a reported exception raises no code-11 fault.
- R10: `vector_o` always carries the handler address 0x80000080.
- R11: EPC (select 2) can be written in kernel mode. Select 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_hw_i | input | 6 | Hardware interrupt lines for pending flags 7..2 |
| exc_valid_i | input | 1 | Core reports an exception this cycle |
| exc_code_i | input | 5 | Code of the reported exception |
| exc_pc_i | input | 32 | Address of the faulting instruction |
| rfe_i | input | 1 | Return-from-exception |
| reg_wr_i | input | 1 | Register write request |
| reg_addr_i | input | 2 | Register select: 0 status, 1 cause, 2 EPC |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the selected register |
| irq_req_o | output | 1 | Interrupt request to the core |
| priv_fault_o | output | 1 | A user-mode write is being refused |
| vector_o | output | 32 | Handler entry address |

## Verification
The bench pushes the mode stack twice, then pops it twice. This shows the old pair is dropped on a push and held on a pop; a stack that shifted in the wrong direction or cleared old on a pop would leave wrong bits 5:0. It enters user mode and attempts an EPC write, which must leave EPC holding the fault address and put code 11 in the cause register. It then sends a user write together with a reported exception, an exception together with a return, and a return together with a write. A design with the ranking wrong would record the wrong code or apply the dropped write. The interrupt request is checked with the line masked, with the global enable off and with both set, so that a gate missing either term raises a request.

// File: rtl/exc_ctrl_pkg.sv
package exc_ctrl_pkg;

    localparam int XLEN       = 32;
    localparam int NUM_IRQ    = 8;
    localparam int NUM_SW_IRQ = 2;
    localparam int NUM_HW_IRQ = NUM_IRQ - NUM_SW_IRQ;
    localparam int CODE_W     = 5;
    localparam int SEL_W      = 2;
    localparam int STK_W      = 6;
    localparam int MASK_LSB   = 8;

    localparam logic [XLEN-1:0] HANDLER_VEC = 32'h8000_0080;

    typedef enum logic [CODE_W-1:0] {
        EXC_INT          = 5'd0,
        EXC_ADDR_LD      = 5'd4,
        EXC_ADDR_ST      = 5'd5,
        EXC_BUS_IFETCH   = 5'd6,
        EXC_BUS_DATA     = 5'd7,
        EXC_SYSCALL      = 5'd8,
        EXC_BREAK        = 5'd9,
        EXC_RSVD_OP      = 5'd10,
        EXC_COP_UNUSABLE = 5'd11,
        EXC_OVERFLOW     = 5'd12,
        EXC_FP           = 5'd15
    } exc_code_e;

    typedef enum logic [SEL_W-1:0] {
        SEL_STATUS = 2'd0,
        SEL_CAUSE  = 2'd1,
        SEL_EPC    = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic ku;   // 1 = user, 0 = kernel
        logic ie;
    } mode_pair_t;

    typedef struct packed {
        mode_pair_t old_p;
        mode_pair_t prev_p;
        mode_pair_t cur_p;
    } mode_stack_t;

    function automatic mode_stack_t stack_push(input mode_stack_t s);
        mode_stack_t n;
        n.old_p  = s.prev_p;
        n.prev_p = s.cur_p;
        n.cur_p  = '{ku: 1'b0, ie: 1'b0};
        return n;
    endfunction

    function automatic mode_stack_t stack_pop(input mode_stack_t s);
        mode_stack_t n;
        n.old_p  = s.old_p;
        n.prev_p = s.old_p;
        n.cur_p  = s.prev_p;
        return n;
    endfunction

    function automatic logic [XLEN-1:0] pack_status(input logic [NUM_IRQ-1:0] im,
                                                    input mode_stack_t s);
        logic [XLEN-1:0] w;
        w = '0;
        w[MASK_LSB +: NUM_IRQ] = im;
        w[STK_W-1:0] = s;
        return w;
    endfunction

    function automatic logic [XLEN-1:0] pack_cause(input logic [NUM_IRQ-1:0] ip,
                                                   input logic [CODE_W-1:0] code);
        logic [XLEN-1:0] w;
        w = '0;
        w[MASK_LSB +: NUM_IRQ] = ip;
        w[2 +: CODE_W] = code;
        return w;
    endfunction

endpackage

// File: rtl/exc_mode_stack.sv
module exc_mode_stack
    import exc_ctrl_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                push_i,
    input  logic                pop_i,
    input  logic                wr_i,
    input  logic [STK_W-1:0]    wdata_i,
    output mode_stack_t         stack_o
);
    mode_stack_t stack_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stack_q <= '0;
        end else if (push_i) begin
            stack_q <= stack_push(stack_q);
        end else if (pop_i) begin
            stack_q <= stack_pop(stack_q);
        end else if (wr_i) begin
            stack_q <= mode_stack_t'(wdata_i);
        end
    end

    assign stack_o = stack_q;
endmodule

// File: rtl/exc_cause_reg.sv
module exc_cause_reg
    import exc_ctrl_pkg::*;
#(
    parameter int N_IRQ = NUM_IRQ,
    parameter int N_SW  = NUM_SW_IRQ,
    localparam int N_HW = N_IRQ - N_SW
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N_HW-1:0]     hw_i,
    input  logic                sw_wr_i,
    input  logic [N_SW-1:0]     sw_wdata_i,
    input  logic                code_wr_i,
    input  logic [CODE_W-1:0]   code_i,
    output logic [N_IRQ-1:0]    ip_o,
    output logic [CODE_W-1:0]   code_o
);
    logic [N_IRQ-1:0]  ip_q;
    logic [CODE_W-1:0] code_q;

    for (genvar g = 0; g < N_IRQ; g++) begin : g_pend
        if (g < N_SW) begin : g_sw
            always_ff @(posedge clk) begin
                if (rst)          ip_q[g] <= 1'b0;
                else if (sw_wr_i) ip_q[g] <= sw_wdata_i[g];
            end
        end else begin : g_hw
            always_ff @(posedge clk) begin
                if (rst) ip_q[g] <= 1'b0;
                else     ip_q[g] <= hw_i[g-N_SW];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)            code_q <= '0;
        else if (code_wr_i) code_q <= code_i;
    end

    assign ip_o   = ip_q;
    assign code_o = code_q;
endmodule

// File: rtl/exc_ctrl_regs.sv
module exc_ctrl_regs
    import exc_ctrl_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_HW_IRQ-1:0] irq_hw_i,
    input  logic                  exc_valid_i,
    input  logic [CODE_W-1:0]     exc_code_i,
    input  logic [XLEN-1:0]       exc_pc_i,
    input  logic                  rfe_i,
    input  logic                  reg_wr_i,
    input  logic [SEL_W-1:0]      reg_addr_i,
    input  logic [XLEN-1:0]       reg_wdata_i,
    output logic [XLEN-1:0]       reg_rdata_o,
    output logic                  irq_req_o,
    output logic                  priv_fault_o,
    output logic [XLEN-1:0]       vector_o
);
    mode_stack_t         stack;
    logic [NUM_IRQ-1:0]  im_q;
    logic [NUM_IRQ-1:0]  ip;
    logic [CODE_W-1:0]   code;
    logic [XLEN-1:0]     epc_q;
    logic [XLEN-1:0]     status_word;
    logic [XLEN-1:0]     cause_word;

    logic                user_mode;
    logic                wr_denied;
    logic                take_exc;
    logic                do_pop;
    logic                wr_ok;
    logic [CODE_W-1:0]   code_eff;
    reg_sel_e            sel;

    assign sel       = reg_sel_e'(reg_addr_i);
    assign user_mode = stack.cur_p.ku;
    assign wr_denied = reg_wr_i && user_mode && !exc_valid_i;
    assign take_exc  = exc_valid_i || wr_denied;
    assign code_eff  = exc_valid_i ? exc_code_i : CODE_W'(EXC_COP_UNUSABLE);
    assign do_pop    = rfe_i && !take_exc;
    assign wr_ok     = reg_wr_i && !user_mode && !take_exc && !rfe_i;

    exc_mode_stack u_stack (
        .clk     (clk),
        .rst     (rst),
        .push_i  (take_exc),
        .pop_i   (do_pop),
        .wr_i    (wr_ok && sel == SEL_STATUS),
        .wdata_i (reg_wdata_i[STK_W-1:0]),
        .stack_o (stack)
    );

    exc_cause_reg #(
        .N_IRQ (NUM_IRQ),
        .N_SW  (NUM_SW_IRQ)
    ) u_cause (
        .clk        (clk),
        .rst        (rst),
        .hw_i       (irq_hw_i),
        .sw_wr_i    (wr_ok && sel == SEL_CAUSE),
        .sw_wdata_i (reg_wdata_i[MASK_LSB +: NUM_SW_IRQ]),
        .code_wr_i  (take_exc),
        .code_i     (code_eff),
        .ip_o       (ip),
        .code_o     (code)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            im_q <= '0;
        end else if (wr_ok && sel == SEL_STATUS) begin
            im_q <= reg_wdata_i[MASK_LSB +: NUM_IRQ];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            epc_q <= '0;
        end else if (take_exc) begin
            epc_q <= exc_pc_i;
        end else if (wr_ok && sel == SEL_EPC) begin
            epc_q <= reg_wdata_i;
        end
    end

    assign status_word = pack_status(im_q, stack);
    assign cause_word  = pack_cause(ip, code);

    always_comb begin
        unique case (sel)
            SEL_STATUS: reg_rdata_o = status_word;
            SEL_CAUSE:  reg_rdata_o = cause_word;
            SEL_EPC:    reg_rdata_o = epc_q;
            default:    reg_rdata_o = '0;
        endcase
    end

    assign irq_req_o    = stack.cur_p.ie && |(ip & im_q);
    assign priv_fault_o = wr_denied;
    assign vector_o     = HANDLER_VEC;
endmodule

// File: rtl/exc_ctrl_regs_chk.sv
module exc_ctrl_regs_chk
    import exc_ctrl_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_HW_IRQ-1:0] irq_hw_i,
    input  logic                  exc_valid_i,
    input  logic [CODE_W-1:0]     exc_code_i,
    input  logic [XLEN-1:0]       exc_pc_i,
    input  logic                  rfe_i,
    input  logic                  reg_wr_i,
    input  logic                  irq_req_o,
    input  logic [XLEN-1:0]       status_w,
    input  logic [XLEN-1:0]       cause_w,
    input  logic [XLEN-1:0]       epc_w
);
    // R3: hardware flags follow the lines one clock later
    p_hw_pending_r3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> cause_w[MASK_LSB+NUM_SW_IRQ +: NUM_HW_IRQ] == $past(irq_hw_i));

    // R4: no request while the current enable is clear
    p_irq_gate_r4: assert property (@(posedge clk) disable iff (rst)
        !status_w[0] |-> !irq_req_o);

    // R5: push of the mode stack on exception entry
    p_stack_push_r5: assert property (@(posedge clk) disable iff (rst)
        exc_valid_i |=> (status_w[1:0] == 2'b00) && (status_w[5:2] == $past(status_w[3:0])));

    // R6: EPC and code captured together
    p_epc_code_r6: assert property (@(posedge clk) disable iff (rst)
        exc_valid_i |=> (epc_w == $past(exc_pc_i)) && (cause_w[6:2] == $past(exc_code_i)));

    // R7: pop keeps old and shifts it down
    p_stack_pop_r7: assert property (@(posedge clk) disable iff (rst)
        (rfe_i && !exc_valid_i && !(reg_wr_i && status_w[1]))
        |=> (status_w[5:4] == $past(status_w[5:4])) && (status_w[3:0] == $past(status_w[5:2])));

    // R8: user write becomes a coprocessor-unusable fault
    p_user_write_r8: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_i && status_w[1] && !exc_valid_i)
        |=> (cause_w[6:2] == 5'd11) && !status_w[1] && (epc_w == $past(exc_pc_i)));
endmodule

bind exc_ctrl_regs exc_ctrl_regs_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .irq_hw_i    (irq_hw_i),
    .exc_valid_i (exc_valid_i),
    .exc_code_i  (exc_code_i),
    .exc_pc_i    (exc_pc_i),
    .rfe_i       (rfe_i),
    .reg_wr_i    (reg_wr_i),
    .irq_req_o   (irq_req_o),
    .status_w    (status_word),
    .cause_w     (cause_word),
    .epc_w       (epc_q)
);

// File: tb/exc_ctrl_regs_tb.sv
`timescale 1ns/100ps
module exc_ctrl_regs_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic [5:0]  irq_hw_i;
    logic        exc_valid_i;
    logic [4:0]  exc_code_i;
    logic [31:0] exc_pc_i;
    logic        rfe_i;
    logic        reg_wr_i;
    logic [1:0]  reg_addr_i;
    logic [31:0] reg_wdata_i;
    logic [31:0] reg_rdata_o;
    logic        irq_req_o;
    logic        priv_fault_o;
    logic [31:0] vector_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    exc_ctrl_regs u_dut (
        .clk          (clk),
        .rst          (rst),
        .irq_hw_i     (irq_hw_i),
        .exc_valid_i  (exc_valid_i),
        .exc_code_i   (exc_code_i),
        .exc_pc_i     (exc_pc_i),
        .rfe_i        (rfe_i),
        .reg_wr_i     (reg_wr_i),
        .reg_addr_i   (reg_addr_i),
        .reg_wdata_i  (reg_wdata_i),
        .reg_rdata_o  (reg_rdata_o),
        .irq_req_o    (irq_req_o),
        .priv_fault_o (priv_fault_o),
        .vector_o     (vector_o)
    );

    typedef struct packed {
        logic [1:0]  sel;
        logic [31:0] wdata;
        logic [31:0] exp;
    } wvec_t;

    // kernel-mode write then read-back (R2, R3, R11)
    localparam wvec_t VEC [6] = '{
        '{sel: 2'd0, wdata: 32'hFFFF_FFFD, exp: 32'h0000_FF3D},
        '{sel: 2'd0, wdata: 32'h0000_0000, exp: 32'h0000_0000},
        '{sel: 2'd1, wdata: 32'hFFFF_FFFF, exp: 32'h0000_0300},
        '{sel: 2'd1, wdata: 32'h0000_0100, exp: 32'h0000_0100},
        '{sel: 2'd2, wdata: 32'h1234_5678, exp: 32'h1234_5678},
        '{sel: 2'd3, wdata: 32'hDEAD_BEEF, exp: 32'h0000_0000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr_i = a;
        #1;
        d = reg_rdata_o;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_addr_i  = a;
        reg_wdata_i = d;
        reg_wr_i    = 1'b1;
        tick();
        reg_wr_i    = 1'b0;
    endtask

    task automatic take_exc(input logic [4:0] c, input logic [31:0] pc);
        exc_valid_i = 1'b1;
        exc_code_i  = c;
        exc_pc_i    = pc;
        tick();
        exc_valid_i = 1'b0;
    endtask

    task automatic do_rfe();
        rfe_i = 1'b1;
        tick();
        rfe_i = 1'b0;
    endtask

    initial begin
        logic [31:0] d;
        rst = 1'b1; irq_hw_i = '0; exc_valid_i = 1'b0; exc_code_i = '0;
        exc_pc_i = '0; rfe_i = 1'b0; reg_wr_i = 1'b0; reg_addr_i = '0; reg_wdata_i = '0;
        repeat (3) tick();
        rst = 1'b0;
        #1;

        // R1 reset state, R10 vector
        rd(2'd0, d); chk("R1 status", d, 32'h0);
        rd(2'd1, d); chk("R1 cause", d, 32'h0);
        rd(2'd2, d); chk("R1 epc", d, 32'h0);
        chk("R1 irq", {31'h0, irq_req_o}, 32'h0);
        chk("R1 priv_fault", {31'h0, priv_fault_o}, 32'h0);
        chk("R10 vector", vector_o, 32'h8000_0080);

        // vector table: R2 R3 R11
        for (int i = 0; i < 6; i++) begin
            wr(VEC[i].sel, VEC[i].wdata);
            rd(VEC[i].sel, d);
            chk($sformatf("R2/R3/R11 vec%0d", i), d, VEC[i].exp);
        end

        // R4: software flag 0 pending, mask it in with IE set
        wr(2'd0, 32'h0000_0101);
        chk("R4 sw line masked in", {31'h0, irq_req_o}, 32'h1);
        wr(2'd0, 32'h0000_0001);
        chk("R4 mask clear", {31'h0, irq_req_o}, 32'h0);
        wr(2'd1, 32'h0000_0000);
        wr(2'd0, 32'h0000_0401);
        chk("R4 no pending", {31'h0, irq_req_o}, 32'h0);
        irq_hw_i = 6'b000001;
        #1;
        chk("R3 line not yet sampled", {31'h0, irq_req_o}, 32'h0);
        tick();
        chk("R4 hw line 2", {31'h0, irq_req_o}, 32'h1);
        rd(2'd1, d); chk("R3 hw flag 2", d, 32'h0000_0400);
        wr(2'd0, 32'h0000_0400);
        chk("R4 IE off", {31'h0, irq_req_o}, 32'h0);
        irq_hw_i = '0;
        tick();
        rd(2'd1, d); chk("R3 hw flag cleared", d, 32'h0);

        // R5 R6: push twice
        wr(2'd0, 32'h0000_0025);
        take_exc(5'd12, 32'h0000_4000);
        rd(2'd0, d); chk("R5 push 1", d, 32'h0000_0014);
        rd(2'd1, d); chk("R6 code 12", d, 32'h0000_0030);
        rd(2'd2, d); chk("R6 epc 1", d, 32'h0000_4000);
        take_exc(5'd8, 32'h0000_5000);
        rd(2'd0, d); chk("R5 push 2 drops old", d, 32'h0000_0010);
        rd(2'd1, d); chk("R6 code 8", d, 32'h0000_0020);
        rd(2'd2, d); chk("R6 epc 2", d, 32'h0000_5000);

        // R7: pop twice
        do_rfe();
        rd(2'd0, d); chk("R7 pop 1", d, 32'h0000_0014);
        do_rfe();
        rd(2'd0, d); chk("R7 pop 2", d, 32'h0000_0015);

        // R8: enter user mode, try a write
        wr(2'd0, 32'h0000_0002);
        exc_pc_i    = 32'h0000_6000;
        reg_addr_i  = 2'd2;
        reg_wdata_i = 32'hFFFF_0000;
        reg_wr_i    = 1'b1;
        #1;
        chk("R8 priv_fault", {31'h0, priv_fault_o}, 32'h1);
        tick();
        reg_wr_i = 1'b0;
        rd(2'd2, d); chk("R8 epc not written", d, 32'h0000_6000);
        rd(2'd1, d); chk("R8 code 11", d, 32'h0000_002C);
        rd(2'd0, d); chk("R8 kernel after fault", d, 32'h0000_0008);

        // R9: user write together with reported exception
        do_rfe();
        rd(2'd0, d); chk("R9 back in user", d, 32'h0000_0002);
        reg_addr_i  = 2'd0;
        reg_wdata_i = 32'h0000_0000;
        reg_wr_i    = 1'b1;
        exc_valid_i = 1'b1;
        exc_code_i  = 5'd4;
        exc_pc_i    = 32'h0000_7000;
        #1;
        chk("R9 no fault with exception", {31'h0, priv_fault_o}, 32'h0);
        tick();
        reg_wr_i = 1'b0; exc_valid_i = 1'b0;
        rd(2'd1, d); chk("R9 reported code wins", d, 32'h0000_0010);
        rd(2'd0, d); chk("R9 push once", d, 32'h0000_0008);

        // R9: exception together with rfe
        rfe_i = 1'b1;
        take_exc(5'd9, 32'h0000_8000);
        rfe_i = 1'b0;
        rd(2'd0, d); chk("R9 exception over rfe", d, 32'h0000_0020);
        rd(2'd1, d); chk("R9 code 9", d, 32'h0000_0024);

        // R9: rfe together with kernel write
        rfe_i = 1'b1;
        wr(2'd0, 32'h0000_FF3F);
        rfe_i = 1'b0;
        rd(2'd0, d); chk("R9 rfe over write", d, 32'h0000_0028);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule